// File: doc/BRIEF.md
# External Interrupt Request Flag Unit

This block holds the single pending-request flag that feeds the external interrupt line of a small 8-bit controller. Two kinds of source can raise the flag. The first is a dedicated interrupt pin, which is always active. The second is a group of four general port pins, which take part only while a configuration enable is high. Each pin passes through its own synchroniser and edge detector. A falling edge on the synchronised level counts as one event. A steady level does not.

Software sees the flag as one read-only bit of a register. Software cannot set the flag by writing. There are two ways to clear it. The CPU clears it automatically when it fetches the interrupt vector. Software can also write 1 to a separate reset bit, which always reads as 0. If a new event arrives in the same cycle as a clear, the event wins, so no request is lost. The request output follows the flag, but only while the global interrupt mask is low.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset, the flag is 0, `int_req` is 0, and `reg_rdata` reads 8'h00.
- R2: A falling edge on `ext_int_n` sets the flag. The flag first reads 1 on the third rising clock edge after the pin changes, and it still reads 0 after the second edge.
- R3: While `port_int_en` is 1, a falling edge on any bit of `port_int_n` sets the flag, with the same latency as R2.
- R4: While `port_int_en` is 0, edges on `port_int_n` leave the flag unchanged.
- R5: A cycle with `vec_fetch` high clears the flag on the next clock edge.
- R6: A register write with bit 1 of `reg_wdata` set to 1 clears the flag. A write with bit 1 set to 0 leaves the flag unchanged.
- R7: Writing 1 to bit 3 (the flag position) does not set the flag. Bit 1 always reads as 0.
- R8: When a pin event and a clear happen in the same cycle, the flag ends up set.
- R9: `int_req` is 1 exactly when the flag is 1 and `int_mask` is 0.
- R10: Rising edges and steady levels on any pin never set the flag.
- R11: While `reg_sel` is 1, `reg_rdata` shows the flag in bit 3 and 0 in every other bit. While `reg_sel` is 0, `reg_rdata` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Selects the flag register for read and write |
| reg_wr | input | 1 | Write strobe, qualified by reg_sel |
| reg_wdata | input | 8 | Write data; bit 1 is the clear request |
| reg_rdata | output | 8 | Read data; bit 3 is the flag |
| vec_fetch | input | 1 | CPU is fetching the interrupt vector this cycle |
| ext_int_n | input | 1 | Dedicated interrupt pin, active on a falling edge |
| port_int_n | input | 4 | Port pins that can act as interrupt sources, active on a falling edge |
| port_int_en | input | 1 | Configuration enable for the port pin sources |
| int_mask | input | 1 | Global interrupt mask |
| int_req | output | 1 | Interrupt request to the CPU |

## Verification
The main check is a table that gives each of the five sources a falling edge, once with the port enable high and once with it low. This separates the always-active dedicated pin from the gated port pins, and it catches a wrong bit index in the port group. For each entry, the rising edge that returns the pin to idle is checked to leave a cleared flag at 0. Directed cases then cover the following:
- The exact three-edge latency.
- Both clear paths.
- A write of 0 to the clear bit.
- A write of 1 to the flag bit.
- An event in the same cycle as a vector fetch, which tells set-priority apart from clear-priority.
- The mask gating the request line.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_mode_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync
   import irq_pkg::*;
#(
   parameter int         STAGES    = 2,
   parameter edge_mode_e EDGE_MODE = EDGE_FALL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic event_o
);
   localparam logic IDLE = (EDGE_MODE == EDGE_FALL);
   localparam int   LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{IDLE}};
         prev_q  <= IDLE;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         prev_q  <= chain_q[LAST];
      end
   end

   if (EDGE_MODE == EDGE_FALL) begin : g_fall
      assign event_o = prev_q & ~chain_q[LAST];
   end else begin : g_rise
      assign event_o = ~prev_q & chain_q[LAST];
   end

   AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      event_o |=> !event_o); // R10
endmodule

// File: rtl/irq_flag_core.sv
module irq_flag_core #(
   parameter int DATA_W   = 8,
   parameter int FLAG_BIT = 3,
   parameter int CLR_BIT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic              vec_fetch_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              flag_o
);
   if (FLAG_BIT == CLR_BIT || FLAG_BIT >= DATA_W || CLR_BIT >= DATA_W) begin : g_bad_bits
      $error("irq_flag_core: flag and clear bit positions must differ and fit DATA_W");
   end

   logic sw_clr, clr;
   assign sw_clr = wr_i & wdata_i[CLR_BIT];
   assign clr    = sw_clr | vec_fetch_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr)   flag_o <= 1'b0;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o); // R8
   AST_VEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_fetch_i && !set_i) |=> !flag_o); // R5
   AST_SW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wdata_i[CLR_BIT] && !set_i) |=> !flag_o); // R6
   AST_WRITE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !vec_fetch_i && !flag_o) |=> !flag_o); // R7
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
   import irq_pkg::*;
#(
   parameter int         DATA_W    = 8,
   parameter int         N_PORT    = 4,
   parameter int         SYNC_DEPTH = 2,
   parameter int         FLAG_BIT  = 3,
   parameter int         CLR_BIT   = 1,
   parameter edge_mode_e EDGE_MODE = EDGE_FALL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              vec_fetch,
   input  logic              ext_int_n,
   input  logic [N_PORT-1:0] port_int_n,
   input  logic              port_int_en,
   input  logic              int_mask,
   output logic              int_req
);
   if (N_PORT < 1) begin : g_bad_port
      $error("irq_flag_unit: N_PORT must be at least 1");
   end

   logic              ext_evt;
   logic [N_PORT-1:0] port_evt;
   logic              any_evt;
   logic              flag;

   irq_pin_sync #(.STAGES(SYNC_DEPTH), .EDGE_MODE(EDGE_MODE)) u_ext_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_int_n), .event_o(ext_evt));

   for (genvar p = 0; p < N_PORT; p++) begin : g_port
      irq_pin_sync #(.STAGES(SYNC_DEPTH), .EDGE_MODE(EDGE_MODE)) u_sync (
         .clk(clk), .rst_n(rst_n), .pin_i(port_int_n[p]), .event_o(port_evt[p]));
   end

   assign any_evt = ext_evt | (port_int_en & (|port_evt));

   irq_flag_core #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT), .CLR_BIT(CLR_BIT)) u_core (
      .clk(clk), .rst_n(rst_n), .set_i(any_evt), .vec_fetch_i(vec_fetch),
      .wr_i(reg_sel & reg_wr), .wdata_i(reg_wdata), .flag_o(flag));

   always_comb begin
      reg_rdata = '0;
      if (reg_sel) reg_rdata[FLAG_BIT] = flag;
   end

   assign int_req = flag & ~int_mask;

   AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      int_mask |-> !int_req); // R9
   AST_PORT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_int_en && !ext_evt && !vec_fetch && !flag) |=> !flag); // R4
   AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[CLR_BIT] == 1'b0); // R7
endmodule

// File: tb/irq_flag_unit_tb.sv
`timescale 1ns/1ps
module irq_flag_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_sel = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       vec_fetch = 1'b0;
   logic       ext_int_n = 1'b1;
   logic [3:0] port_int_n = 4'hF;
   logic       port_int_en = 1'b0;
   logic       int_mask = 1'b0;
   logic       int_req;
   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   irq_flag_unit dut_i (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_fetch(vec_fetch),
      .ext_int_n(ext_int_n), .port_int_n(port_int_n), .port_int_en(port_int_en),
      .int_mask(int_mask), .int_req(int_req));

   // entry: {source[2:0] (0..3 port bit, 4 dedicated pin), enable, expected flag}
   localparam logic [4:0] VEC [10] = '{
      {3'd4, 1'b0, 1'b1}, {3'd4, 1'b1, 1'b1},
      {3'd0, 1'b1, 1'b1}, {3'd1, 1'b1, 1'b1}, {3'd2, 1'b1, 1'b1}, {3'd3, 1'b1, 1'b1},
      {3'd0, 1'b0, 1'b0}, {3'd1, 1'b0, 1'b0}, {3'd2, 1'b0, 1'b0}, {3'd3, 1'b0, 1'b0}};

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0; reg_wdata = 8'h00;
   endtask

   task automatic drive(input int src, input logic lvl);
      if (src == 4) ext_int_n = lvl; else port_int_n[src] = lvl;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      reg_sel = 1'b1;
      #0.1;
      chk("R1 rdata in reset", reg_rdata, 8'h00);
      chk("R1 int_req in reset", {7'd0, int_req}, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 flag after reset", reg_rdata, 8'h00);

      // table walk: R2 R3 R4 R10
      for (int i = 0; i < 10; i++) begin
         automatic int   src = int'(VEC[i][4:2]);
         automatic logic exp = VEC[i][0];
         port_int_en = VEC[i][1];
         @(negedge clk); drive(src, 1'b0);
         repeat (3) @(posedge clk);
         @(negedge clk);
         chk($sformatf("R3/R4 vec %0d src %0d", i, src), reg_rdata, {4'd0, exp, 3'd0});
         wr(8'h02);
         chk("R6 clear after vector", reg_rdata, 8'h00);
         drive(src, 1'b1);
         repeat (5) @(negedge clk);
         chk("R10 rising edge no set", reg_rdata, 8'h00);
      end
      port_int_en = 1'b0;

      // R2 exact latency
      @(negedge clk); ext_int_n = 1'b0;
      repeat (2) @(posedge clk); @(negedge clk);
      chk("R2 not yet after two edges", reg_rdata, 8'h00);
      @(negedge clk);
      chk("R2 set after third edge", reg_rdata, 8'h08);
      chk("R9 request unmasked", {7'd0, int_req}, 8'h01);
      int_mask = 1'b1; #0.1;
      chk("R9 request masked", {7'd0, int_req}, 8'h00);
      int_mask = 1'b0;
      repeat (4) @(negedge clk);
      chk("R10 steady low no change", reg_rdata, 8'h08);
      reg_sel = 1'b0; #0.1;
      chk("R11 deselected reads zero", reg_rdata, 8'h00);
      reg_sel = 1'b1;

      // R6 write 0 to clear bit, R7 other bits
      wr(8'hFD);
      chk("R6 write 0 no clear", reg_rdata, 8'h08);
      // R5 vector fetch clears
      @(negedge clk); vec_fetch = 1'b1;
      @(negedge clk); vec_fetch = 1'b0;
      chk("R5 vector fetch clears", reg_rdata, 8'h00);
      chk("R9 request drops", {7'd0, int_req}, 8'h00);
      wr(8'h08);
      chk("R7 write flag bit ignored", reg_rdata, 8'h00);
      wr(8'hFF);
      chk("R7 clear bit reads zero", reg_rdata, 8'h00);
      ext_int_n = 1'b1;
      repeat (4) @(negedge clk);

      // R8 event coincides with vector fetch
      port_int_en = 1'b1;
      @(negedge clk); port_int_n[2] = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk); vec_fetch = 1'b1;
      @(negedge clk); vec_fetch = 1'b0;
      chk("R8 set wins over vector fetch", reg_rdata, 8'h08);
      port_int_n[2] = 1'b1;
      repeat (4) @(negedge clk);
      // R8 event coincides with software clear
      @(negedge clk); port_int_n[1] = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h02;
      @(negedge clk); reg_wr = 1'b0; reg_wdata = 8'h00;
      chk("R8 set wins over software clear", reg_rdata, 8'h08);
      wr(8'h02);
      chk("R6 final clear", reg_rdata, 8'h00);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule